// File: doc/BRIEF.md
# Multicycle Shared-ALU Processor Datapath

This block is the datapath of a 32-bit load/store processor that runs each instruction over several clock cycles. One memory array holds both instructions and data. One ALU does every add and compare the processor needs: the PC step, branch targets, effective addresses and register arithmetic. Holding registers carry values from one cycle to the next: the instruction word, the memory data word, the two register operands and the ALU result. A control sequencer outside the block drives the per-cycle control pins. The block sends back the instruction's opcode and function fields and the ALU zero flag, so the sequencer can choose its next step.

The memory is filled through a small valid/ready load stream. A word is accepted on a clock edge when `ld_valid` and `ld_ready` are both high. `ld_ready` drops for any cycle in which the datapath itself stores to memory. The store then takes the single write port, and the load word waits with its address and data held stable until a later cycle. A source may raise `ld_valid` at any time and must not withdraw a word before it is accepted.

Top module: `mcd_datapath`

## Requirements
- R1: A synchronous active-high reset clears the PC and the instruction register, so `opcode` and `funct` read 0 after reset, and the first fetch returns memory word 0.
- R2: The instruction register loads memory read data only in cycles with `ir_write`=1. With `alu_src_a`=0 (PC), `alu_src_b`=01 (constant 4), `alu_op`=000 (add), `pc_source`=0 (direct ALU result) and `pc_write`=1, the PC advances by 4, so successive fetches return successive words.
- R3: The memory byte address is the PC when `iord`=0 and the ALU result register when `iord`=1. Word index is address bits [MEM_AW+1:2]; an address outside the array, or not word aligned, reads 0 and is never written. With `reg_write`=1, `reg_dst`=0 and `mem_to_reg`=1, the memory data register is written to register IR[20:16].
- R4: `alu_op` codes: 000 add, 001 subtract, 010 AND, 011 OR, 100 signed set-less-than (result 1 or 0). `zero` is 1 exactly when the ALU result is 0.
- R5: Register 0 reads as zero even after a write is attempted to it.
- R6: With `reg_write`=1, `reg_dst`=1 and `mem_to_reg`=0, the ALU result register is written to register IR[15:11].
- R7: With `pc_write_cond`=1 and `pc_source`=1, the PC loads the ALU result register only when `zero` is 1; otherwise the PC holds.
- R8: With `pc_write`=1 and `pc_source`=2, the PC loads {PC[31:28], IR[25:0], 2'b00}.
- R9: `ld_ready` is 0 in every cycle with `mem_write`=1 and 1 otherwise. A datapath store is never overwritten by a load in the same cycle, and an accepted load word is readable from the next cycle on.
- R10: Register read ports use IR[25:21] (first operand) and IR[20:16] (second operand). `alu_src_b`=10 selects the sign-extended IR[15:0], and `alu_src_b`=11 selects that value shifted left by 2.
- R11: With `mem_write`=1 the second operand register is written to the addressed word. With `iord`=1 and `ir_write`=1 a data word is brought into the instruction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load stream word present |
| ld_ready | output | 1 | Load stream word can be accepted this cycle |
| ld_addr | input | MEM_AW | Word index for the load stream |
| ld_data | input | 32 | Load stream data word |
| iord | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_read | input | 1 | Enable memory read data |
| mem_write | input | 1 | Store second operand register to memory |
| ir_write | input | 1 | Load instruction register |
| reg_dst | input | 1 | Write register select: 0 IR[20:16], 1 IR[15:11] |
| mem_to_reg | input | 1 | Write data select: 0 ALU result register, 1 memory data register |
| reg_write | input | 1 | Register file write enable |
| alu_src_a | input | 1 | First ALU operand: 0 PC, 1 first operand register |
| alu_src_b | input | 2 | Second ALU operand select |
| alu_op | input | 3 | ALU operation code |
| pc_source | input | 2 | PC next-value select |
| pc_write | input | 1 | Unconditional PC write |
| pc_write_cond | input | 1 | PC write when zero is set |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | ALU result equals zero |

## Verification
The bench builds the block with the default MEM_WORDS of 64, a 256-byte space. The program occupies words 0 to 31 and data sits from word 32 upward. A store target at word 48 and a jump target at word 30 then fall inside the array, and a base register plus a negative offset still lands on a real word. That size also lets a single load stream of 64 words fill the whole image before the run. Because the bench can reach every word, it can fetch from a branch target and a jump target, read back a stored word through the instruction register, and make a load word collide with a store at the same address.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int WORD_W = 32;
  localparam int REG_AW = 5;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;
endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
(
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [2:0]        op,
  output logic [WORD_W-1:0] y,
  output logic              is_zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = opa - opb;
      ALU_AND: y = opa & opb;
      ALU_OR:  y = opa | opb;
      ALU_SLT: y = {{(WORD_W-1){1'b0}}, ($signed(opa) < $signed(opb))};
      default: y = opa + opb;
    endcase
  end

  assign is_zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile
  import mcd_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     ra_a,
  input  logic [AW-1:0]     ra_b,
  output logic [WORD_W-1:0] rd_a,
  output logic [WORD_W-1:0] rd_b
);
  logic [WORD_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  // R6 / R3: a write to a nonzero register lands on the next edge
  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/mcd_mem.sv
module mcd_mem
  import mcd_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [AW-1:0]     ld_idx,
  input  logic [WORD_W-1:0] ld_data
);
  logic [WORD_W-1:0] store [WORDS];
  logic [AW-1:0]     idx;
  logic              hit;

  assign idx      = addr[AW+1:2];
  assign hit      = (addr[WORD_W-1:AW+2] == '0) && (addr[1:0] == 2'b00);
  assign ld_ready = !wr_en;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (hit) store[idx] <= wdata;
    end else if (ld_valid) begin
      store[ld_idx] <= ld_data;
    end
  end

  assign rdata = (rd_en && hit) ? store[idx] : '0;

  // R9: a datapath store is what the word holds afterwards
  a_r9_store_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |=> store[$past(idx)] == $past(wdata));
  // R9: an accepted load word is in place on the next cycle
  a_r9_load_lands: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready) |=> store[$past(ld_idx)] == $past(ld_data));
endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
  import mcd_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int MEM_AW = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  input  logic              iord,
  input  logic              mem_read,
  input  logic              mem_write,
  input  logic              ir_write,
  input  logic              reg_dst,
  input  logic              mem_to_reg,
  input  logic              reg_write,
  input  logic              alu_src_a,
  input  logic [1:0]        alu_src_b,
  input  logic [2:0]        alu_op,
  input  logic [1:0]        pc_source,
  input  logic              pc_write,
  input  logic              pc_write_cond,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic              zero
);
  logic [WORD_W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [WORD_W-1:0] mem_addr, mem_rdata, rf_a, rf_b, rf_wdata;
  logic [WORD_W-1:0] alu_a, alu_b, alu_y, imm_sx, pc_next;
  logic [REG_AW-1:0] rf_waddr;
  logic              pc_en;

  assign imm_sx   = {{16{ir_q[15]}}, ir_q[15:0]};
  assign mem_addr = iord ? alu_out_q : pc_q;
  assign rf_waddr = reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata = mem_to_reg ? mdr_q : alu_out_q;
  assign alu_a    = alu_src_a ? a_q : pc_q;

  always_comb begin
    case (alu_src_b)
      2'b00:   alu_b = b_q;
      2'b01:   alu_b = 32'd4;
      2'b10:   alu_b = imm_sx;
      default: alu_b = {imm_sx[WORD_W-3:0], 2'b00};
    endcase
  end

  always_comb begin
    case (pc_source)
      2'd1:    pc_next = alu_out_q;
      2'd2:    pc_next = {pc_q[31:28], ir_q[25:0], 2'b00};
      default: pc_next = alu_y;
    endcase
  end

  assign pc_en = pc_write | (pc_write_cond & zero);

  mcd_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .rst(rst), .addr(mem_addr), .rd_en(mem_read),
    .wr_en(mem_write), .wdata(b_q), .rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_idx(ld_addr), .ld_data(ld_data)
  );

  mcd_regfile #(.NREGS(32)) u_rf (
    .clk(clk), .rst(rst), .we(reg_write), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_a(ir_q[25:21]), .ra_b(ir_q[20:16]), .rd_a(rf_a), .rd_b(rf_b)
  );

  mcd_alu u_alu (.opa(alu_a), .opb(alu_b), .op(alu_op), .y(alu_y), .is_zero(zero));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ir_q <= '0;
    end else begin
      if (pc_en)    pc_q <= pc_next;
      if (ir_write) ir_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    mdr_q     <= mem_rdata;
    a_q       <= rf_a;
    b_q       <= rf_b;
    alu_out_q <= alu_y;
  end

  assign opcode = ir_q[31:26];
  assign funct  = ir_q[5:0];

  // R2: instruction register holds without ir_write
  a_r2_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ir_write |=> $stable(ir_q));
  // R2: the fetch setting steps the PC by four
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (pc_write && pc_source == 2'd0 && !alu_src_a && alu_src_b == 2'b01 && alu_op == ALU_ADD)
    |=> pc_q == $past(pc_q) + 32'd4);
  // R7: no write enable, no PC change
  a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
    (!pc_write && !pc_write_cond) |=> $stable(pc_q));
  // R7: conditional write with a nonzero result leaves the PC alone
  a_r7_not_taken: assert property (@(posedge clk) disable iff (rst)
    (pc_write_cond && !pc_write && !zero) |=> $stable(pc_q));
  // R8: jump keeps the top region bits and word alignment
  a_r8_jump_region: assert property (@(posedge clk) disable iff (rst)
    (pc_write && pc_source == 2'd2)
    |=> (pc_q[31:28] == $past(pc_q[31:28])) && (pc_q[1:0] == 2'b00));
  // R4: subtracting equal operands raises zero
  a_r4_sub_equal: assert property (@(posedge clk) disable iff (rst)
    (alu_op == ALU_SUB && alu_a == alu_b) |-> zero);
endmodule

// File: tb/mcd_datapath_tb_top.sv
module mcd_datapath_tb_top;
  localparam int MW = 64;
  localparam int K_IR = 0, K_Z = 1, K_RDY = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_valid = 1'b0;
  logic ld_ready;
  logic [5:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic iord, mem_read, mem_write, ir_write, reg_dst, mem_to_reg, reg_write, alu_src_a;
  logic [1:0] alu_src_b, pc_source;
  logic [2:0] alu_op;
  logic pc_write, pc_write_cond;
  logic [5:0] opcode, funct;
  logic zero;

  always #2 clk = ~clk;

  mcd_datapath #(.MEM_WORDS(MW)) dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_data(ld_data), .iord(iord), .mem_read(mem_read), .mem_write(mem_write),
    .ir_write(ir_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_write(reg_write),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op), .pc_source(pc_source),
    .pc_write(pc_write), .pc_write_cond(pc_write_cond), .opcode(opcode), .funct(funct),
    .zero(zero)
  );

  typedef struct packed {
    logic iord, mr, mw, irw, rdst, m2r, rw, sa;
    logic [1:0] sb;
    logic [2:0] op;
    logic [1:0] ps;
    logic pw, pwc;
  } ctl_t;

  typedef struct {
    int kind;
    logic [31:0] exp;
    string req;
  } item_t;

  item_t exp_q[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] img [MW];

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] t);
    return {op, t};
  endfunction

  function automatic ctl_t c_idle();
    return '0;
  endfunction
  function automatic ctl_t c_fetch();
    ctl_t c = '0;
    c.mr = 1; c.irw = 1; c.sb = 2'b01; c.pw = 1;
    return c;
  endfunction
  function automatic ctl_t c_decode();
    ctl_t c = '0;
    c.sb = 2'b11;
    return c;
  endfunction
  function automatic ctl_t c_exec(logic [2:0] op, logic [1:0] sb);
    ctl_t c = '0;
    c.sa = 1; c.sb = sb; c.op = op;
    return c;
  endfunction

  task automatic drive(input ctl_t c);
    iord = c.iord; mem_read = c.mr; mem_write = c.mw; ir_write = c.irw;
    reg_dst = c.rdst; mem_to_reg = c.m2r; reg_write = c.rw; alu_src_a = c.sa;
    alu_src_b = c.sb; alu_op = c.op; pc_source = c.ps; pc_write = c.pw;
    pc_write_cond = c.pwc;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic void want(int k, logic [31:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    exp_q.push_back(it);
  endfunction

  // Monitor: pops the scoreboard at each falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        K_IR:    act = {20'd0, opcode, funct};
        K_Z:     act = {31'd0, zero};
        default: act = {31'd0, ld_ready};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] irf(logic [31:0] w);
    return {20'd0, w[31:26], w[5:0]};
  endfunction

  task automatic fetch_decode(input int w, input string r);
    drive(c_fetch()); tick();
    drive(c_decode()); want(K_IR, irf(img[w]), r); tick();
  endtask

  task automatic do_load(input int w, input string r);
    ctl_t c;
    fetch_decode(w, r);
    drive(c_exec(3'd0, 2'b10)); tick();
    c = c_exec(3'd0, 2'b10); c.iord = 1; c.mr = 1; drive(c); tick();
    c = '0; c.rw = 1; c.m2r = 1; drive(c); tick();
  endtask

  task automatic zchk(input logic [2:0] op, input logic z, input string r);
    drive(c_exec(op, 2'b00)); want(K_Z, {31'd0, z}, r); tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    ctl_t c;
    for (int i = 0; i < MW; i++) img[i] = '0;
    img[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0080);
    img[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0084);
    img[2]  = enc_i(6'h23, 5'd0, 5'd3, 16'h0088);
    img[3]  = enc_i(6'h23, 5'd0, 5'd4, 16'h008C);
    img[4]  = enc_i(6'h23, 5'd0, 5'd5, 16'h0090);
    img[5]  = enc_i(6'h23, 5'd0, 5'd6, 16'h0094);
    img[6]  = enc_i(6'h23, 5'd6, 5'd7, 16'hFFF8);
    img[7]  = enc_i(6'h23, 5'd0, 5'd0, 16'h0090);
    img[8]  = enc_r(5'd7, 5'd1, 5'd0, 6'h22);
    img[9]  = enc_r(5'd1, 5'd2, 5'd0, 6'h23);
    img[10] = enc_r(5'd1, 5'd2, 5'd0, 6'h24);
    img[11] = enc_r(5'd2, 5'd1, 5'd0, 6'h2A);
    img[12] = enc_r(5'd1, 5'd3, 5'd0, 6'h2B);
    img[13] = enc_r(5'd1, 5'd2, 5'd8, 6'h25);
    img[14] = enc_r(5'd8, 5'd4, 5'd0, 6'h26);
    img[15] = enc_r(5'd0, 5'd5, 5'd0, 6'h27);
    img[16] = enc_i(6'h2B, 5'd0, 5'd4, 16'h00C0);
    img[17] = enc_i(6'h04, 5'd1, 5'd7, 16'h0003);
    img[18] = enc_j(6'h3F, 26'd18);
    img[19] = enc_j(6'h3E, 26'd19);
    img[20] = enc_j(6'h3D, 26'd20);
    img[21] = enc_i(6'h05, 5'd1, 5'd2, 16'h0005);
    img[22] = enc_j(6'h02, 26'd30);
    img[23] = enc_j(6'h3C, 26'd23);
    img[30] = enc_r(5'd3, 5'd4, 5'd5, 6'h15);
    img[31] = enc_i(6'h11, 5'd2, 5'd3, 16'h0019);
    img[32] = 32'h0000_00F0;
    img[33] = 32'h0000_000F;
    img[34] = 32'hFFFF_FF10;
    img[35] = 32'h0000_00FF;
    img[36] = 32'hFFFF_FFFF;
    img[37] = 32'h0000_00A0;
    img[38] = 32'h0000_00F0;

    drive(c_idle());
    tick();
    for (int i = 0; i < MW; i++) begin
      ld_valid = 1; ld_addr = 6'(i); ld_data = img[i]; tick();
    end
    ld_valid = 0;
    rst = 0;
    want(K_IR, 32'd0, "R1 reset clears IR");
    tick();

    // R1 first fetch is word 0; R3 loads; R10 negative offset; R5 write to r0
    fetch_decode(0, "R1 fetch from address 0");
    drive(c_exec(3'd0, 2'b10)); tick();
    c = c_exec(3'd0, 2'b10); c.iord = 1; c.mr = 1; drive(c); tick();
    c = '0; c.rw = 1; c.m2r = 1; drive(c); tick();
    for (int w = 1; w <= 7; w++) do_load(w, "R2 sequential fetch");

    fetch_decode(8, "R2 fetch");
    zchk(3'd1, 1'b1, "R10 sign-extended negative offset load equals r1 (R3)");
    fetch_decode(9, "R2 fetch");
    zchk(3'd1, 1'b0, "R3 loaded r1 differs from r2");
    fetch_decode(10, "R2 fetch");
    zchk(3'd2, 1'b1, "R4 AND F0&0F");
    zchk(3'd3, 1'b0, "R4 OR F0|0F");
    zchk(3'd4, 1'b1, "R4 SLT F0<0F false");
    zchk(3'd1, 1'b0, "R4 SUB F0-0F");
    zchk(3'd0, 1'b0, "R4 ADD F0+0F");
    fetch_decode(11, "R2 fetch");
    zchk(3'd4, 1'b0, "R4 SLT 0F<F0 true");
    fetch_decode(12, "R2 fetch");
    zchk(3'd0, 1'b1, "R4 ADD F0 + -F0 wraps to 0");
    zchk(3'd4, 1'b1, "R4 SLT signed F0 < -F0 false");

    fetch_decode(13, "R2 fetch");
    drive(c_exec(3'd3, 2'b00)); tick();
    c = '0; c.rw = 1; c.rdst = 1; drive(c); tick();
    fetch_decode(14, "R2 fetch");
    zchk(3'd1, 1'b1, "R6 r8 written with OR result FF");
    fetch_decode(15, "R2 fetch");
    zchk(3'd2, 1'b1, "R5 r0 still zero after write attempt");

    // R11 store with R9 colliding load at the same word
    fetch_decode(16, "R2 fetch");
    drive(c_exec(3'd0, 2'b10)); tick();
    c = c_exec(3'd0, 2'b10); c.iord = 1; c.mw = 1; drive(c);
    ld_valid = 1; ld_addr = 6'd48; ld_data = 32'hDEAD_BE15;
    want(K_RDY, 32'd0, "R9 ld_ready low during store");
    tick();
    c = c_exec(3'd0, 2'b10); c.iord = 1; c.mr = 1; c.irw = 1; drive(c);
    want(K_RDY, 32'd1, "R9 ld_ready high without store");
    tick();
    ld_valid = 0;
    want(K_IR, irf(32'h0000_00FF), "R11 stored word read back into IR");
    tick();
    drive(c_idle());
    want(K_IR, irf(32'hDEAD_BE15), "R9 waiting load word written after store");
    tick();

    // R7 taken branch, not taken branch; R8 jump
    fetch_decode(17, "R2 fetch");
    c = c_exec(3'd1, 2'b00); c.pwc = 1; c.ps = 2'd1; drive(c);
    want(K_Z, 32'd1, "R7 branch compare equal"); tick();
    fetch_decode(21, "R7 taken branch target (R10 shifted offset)");
    c = c_exec(3'd1, 2'b00); c.pwc = 1; c.ps = 2'd1; drive(c);
    want(K_Z, 32'd0, "R7 branch compare unequal"); tick();
    fetch_decode(22, "R7 not taken falls through");
    c = '0; c.pw = 1; c.ps = 2'd2; drive(c); tick();
    fetch_decode(30, "R8 jump target");
    fetch_decode(31, "R2 fetch after jump");

    drive(c_idle());
    tick(); tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule